// File: doc/BRIEF.md
# Circular Record Readout Sequencer

This block drains a finished capture from a circular sample buffer. When capture ends, a strobe arrives together with the address at which the record begins, usually derived from the trigger point. The sequencer then issues one read per cycle to the buffer RAM. Reads start at that address, step through every location and wrap at the end of the buffer, so exactly one full record is read in age order.

The RAM answers after a fixed number of cycles. The sequencer tracks which of those answer slots belong to its own reads. It forwards each returned word, with the RAM's valid flag, one register later toward a downstream width adapter. When the last slot of the record has been forwarded, a finish flag rises. The flag stays high until a new capture is armed or the next readout is started. This tells the system that it is ready for a new configuration.

Top module: `ring_readout`

## Requirements
- R1: After reset, `ram_rd_o`, `out_valid_o` and `done_o` are 0.
- R2: A `start_i` pulse sampled while the block is idle (no read in flight and no answer pending) starts a readout. On the next cycle `ram_rd_o` is 1 and `ram_addr_o` equals the sampled `start_addr_i`.
- R3: A readout issues exactly DEPTH reads on consecutive cycles. Each address is the previous address plus one, wrapping from DEPTH-1 to 0.
- R4: A read issued in cycle t has its answer sampled from `ram_data_i`/`ram_valid_i` in cycle t+RD_LAT. If `ram_valid_i` is 1 there, `out_valid_o` is 1 in cycle t+RD_LAT+1 with `out_data_o` equal to that RAM word.
- R5: If `ram_valid_i` is 0 in an answer slot, no output word is produced for that slot, and the readout still completes and finishes.
- R6: `ram_valid_i` outside the answer slots of the sequencer's own reads never produces `out_valid_o`.
- R7: `done_o` rises in the same cycle as the output of the last answer slot of the record. It then stays 1, and no read is issued, until `arm_i` or an accepted `start_i`.
- R8: `arm_i` clears `done_o` on the next cycle. A `start_i` pulse during an ongoing readout is ignored: the address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture-finished strobe, starts a readout |
| start_addr_i | input | ADDR_W | First address of the record (below DEPTH) |
| arm_i | input | 1 | New capture armed, clears the finish flag |
| ram_rd_o | output | 1 | RAM read request |
| ram_addr_o | output | ADDR_W | RAM read address |
| ram_data_i | input | DATA_W | RAM read data |
| ram_valid_i | input | 1 | RAM read data valid |
| out_data_o | output | DATA_W | Data toward the width adapter |
| out_valid_o | output | 1 | Output data valid |
| done_o | output | 1 | Readout finished, ready for new configuration |

## Verification
The bench builds the block with DEPTH 6, which is not a power of two. This makes the wrap from 5 to 0 a real modulo step rather than a free counter rollover. RD_LAT 2 puts two answers in flight at once, so the pipeline that aligns slots is exercised and a dropped RAM valid lands mid-stream. Start addresses 0, 3 and 5 cover the case with no wrap, a wrap in the middle and a wrap right after the first read.

// File: rtl/ring_readout.sv
module ring_readout #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              arm_i,
  output logic              ram_rd_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_data_i,
  input  logic              ram_valid_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              busy;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] rd_cnt;
  logic [ADDR_W-1:0] ret_cnt;
  logic [RD_LAT-1:0] slot;
  logic              start_ok;
  logic              slot_now;
  logic              last_ret;

  assign slot_now   = slot[RD_LAT-1];
  assign start_ok   = start_i && !busy && (slot == '0);
  assign last_ret   = slot_now && (ret_cnt == LAST);
  assign ram_rd_o   = busy;
  assign ram_addr_o = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_addr <= '0;
      rd_cnt  <= '0;
    end else if (start_ok) begin
      busy    <= 1'b1;
      rd_addr <= start_addr_i;
      rd_cnt  <= '0;
    end else if (busy) begin
      rd_addr <= (rd_addr == LAST) ? '0 : rd_addr + 1'b1;
      rd_cnt  <= rd_cnt + 1'b1;
      if (rd_cnt == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
    end else begin
      slot[0] <= busy;
      for (int i = 1; i < RD_LAT; i++) slot[i] <= slot[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_cnt     <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= slot_now && ram_valid_i;
      out_data_o  <= ram_data_i;
      if (start_ok)      ret_cnt <= '0;
      else if (slot_now) ret_cnt <= ret_cnt + 1'b1;
      if (last_ret)                done_o <= 1'b1;
      else if (start_ok || arm_i)  done_o <= 1'b0;
    end
  end

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_ok) |-> ram_rd_o && ram_addr_o == $past(start_addr_i)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_o && $past(ram_rd_o) && !$past(start_ok) |->
      ram_addr_o == (($past(ram_addr_o) == LAST) ? '0 : $past(ram_addr_o) + 1'b1)); // R3
  AST_OUT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(slot_now) && $past(ram_valid_i)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ram_rd_o); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_o) && !$past(arm_i) && !$past(start_i) |-> done_o); // R7
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_i) && $past(done_o) |-> !done_o); // R8
endmodule

// File: tb/ring_readout_tb_top.sv
module ring_readout_tb_top;
  localparam int D  = 6;
  localparam int DW = 8;
  localparam int RL = 2;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic arm_i = 1'b0;
  logic ram_rd_o;
  logic [AW-1:0] ram_addr_o;
  logic [DW-1:0] ram_data_i;
  logic ram_valid_i;
  logic [DW-1:0] out_data_o;
  logic out_valid_o;
  logic done_o;

  int n_chk = 0;
  int n_fail = 0;
  int kill_addr = -1;
  logic spur = 1'b0;

  always #2 clk = ~clk;

  ring_readout #(.DEPTH(D), .DATA_W(DW), .RD_LAT(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .arm_i(arm_i), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
    .ram_data_i(ram_data_i), .ram_valid_i(ram_valid_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .done_o(done_o));

  function automatic logic [DW-1:0] mem(int a);
    return DW'(a * 37 + 11);
  endfunction

  logic [DW-1:0] pd [RL];
  logic          pv [RL];
  initial for (int i = 0; i < RL; i++) begin pd[i] = '0; pv[i] = 1'b0; end
  always @(posedge clk) begin
    pd[0] <= mem(int'(ram_addr_o));
    pv[0] <= ram_rd_o && (int'(ram_addr_o) != kill_addr);
    for (int i = 1; i < RL; i++) begin pd[i] <= pd[i-1]; pv[i] <= pv[i-1]; end
  end
  assign ram_data_i  = spur ? 8'hA5 : pd[RL-1];
  assign ram_valid_i = spur | pv[RL-1];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int s, int ka, bit poke);
    int nrd = 0, j = 0, nout = 0, nexp;
    bit seen = 0;
    kill_addr = ka;
    nexp = (ka >= 0) ? D - 1 : D;
    @(negedge clk); start_addr_i = AW'(s); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(ram_rd_o == 1'b1 && int'(ram_addr_o) == s, "R2", int'(ram_addr_o), s);
    for (int c = 0; c < D + RL + 4; c++) begin
      if (poke && c == 2) begin start_addr_i = AW'((s + 3) % D); start_i = 1'b1; end
      if (poke && c == 3) start_i = 1'b0;
      if (ram_rd_o) begin
        chk(int'(ram_addr_o) == (s + nrd) % D, "R3 R8", int'(ram_addr_o), (s + nrd) % D);
        nrd++;
      end
      if (out_valid_o) begin
        while (j < D && (s + j) % D == ka) j++;
        chk(out_data_o == mem((s + j) % D), "R4 R5", int'(out_data_o), int'(mem((s + j) % D)));
        j++; nout++;
      end
      if (done_o && !seen) begin
        seen = 1;
        chk(c == D + RL, "R7 rise cycle", c, D + RL);
      end
      @(negedge clk);
    end
    kill_addr = -1;
    chk(nrd == D, "R3 read count", nrd, D);
    chk(nout == nexp, "R5 output count", nout, nexp);
    chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
    arm_i = 1'b1; @(negedge clk); arm_i = 1'b0;
    chk(done_o == 1'b0, "R8 arm clears", int'(done_o), 0);
  endtask

  localparam int NV = 5;
  localparam int V_S [NV] = '{0, 3, 5, 2, 4};
  localparam int V_K [NV] = '{-1, -1, -1, 4, 4};

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_rd_o == 0 && out_valid_o == 0 && done_o == 0, "R1",
        int'({ram_rd_o, out_valid_o, done_o}), 0);
    for (int v = 0; v < NV; v++) run(V_S[v], V_K[v], 1'b0);
    spur = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid_o == 1'b0, "R6 stray valid", int'(out_valid_o), 0);
    end
    spur = 1'b0;
    run(1, -1, 1'b1);
    run(5, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule